// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent page translations so that a virtual byte address can be turned into a physical byte address without a page-table read. Pages are 4 KB. A lookup compares the 19-bit page number of a 31-bit virtual address against every stored entry at once; on a match, the stored 15-bit physical page number is placed above the untouched 12-bit offset to form a 27-bit physical address. When no entry matches, the hit flag stays low so that the page-table walker can be started.

A separate fill port installs translations. A fill whose virtual page is already stored rewrites that entry in place, so a page never has two live copies. Otherwise the caller may name a target slot, or leave the choice to the block: the lowest-numbered empty slot first, and once every slot is full, a rotating victim pointer. A flush input empties the whole buffer in one cycle.

Top module: `va_xlat_buffer`

## Requirements
- R1: After a cycle with reset high, every entry is empty: every lookup reports hit low and phys_addr zero.
- R2: A lookup whose page number (lookup_va[30:12]) matches a valid entry raises hit in the same cycle, and phys_addr equals that entry's physical page in bits [26:12] above lookup_va[11:0].
- R3: While hit is low, phys_addr is zero.
- R4: A fill accepted at a clock edge is visible to lookups from the cycle after that edge, and not before it.
- R5: A fill whose page number already sits in a valid entry rewrites that entry's physical page, leaves every other entry untouched, and at most one valid entry ever matches a page.
- R6: A fill of a new page, without a named slot, goes to the lowest-numbered empty slot when one exists.
- R7: A fill of a new page, without a named slot, into a full buffer replaces the slot held by a victim pointer that starts at 0 after reset, moves up by one only on such fills, and wraps from ENTRIES-1 to 0.
- R8: A fill of a new page with fill_use_idx high and fill_idx below ENTRIES writes slot fill_idx and leaves the victim pointer unchanged.
- R9: flush high empties every entry at the next edge; a fill in the same cycle is discarded.
- R10: With page 0x7FFFD mapped to 0x0000 and page 0x00002 mapped to 0x7FFF, virtual address 0x247C gives physical address 0x7FFF47C with hit high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry at the next edge |
| lookup_va | input | 31 | Virtual byte address to translate |
| hit | output | 1 | A valid entry matches the page number |
| phys_addr | output | 27 | Translated physical address, zero on a miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 19 | Virtual page number to install |
| fill_ppn | input | 15 | Physical page number to install |
| fill_use_idx | input | 1 | Write the named slot instead of the chosen one |
| fill_idx | input | clog2(ENTRIES) | Named slot for a fill |

## Verification
Flush and fill can land on the same edge, and a lookup can ask for a page in the very cycle its fill is presented. The bench drives a flush together with a fill of a fresh page and then looks up both that page and an older one, expecting both to miss; it also presents a lookup of the page being filled and expects a miss before the edge and a hit after it. Slot choice is judged indirectly, by which earlier pages still hit after later fills.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    TGT_SAME   = 2'd0,
    TGT_PICKED = 2'd1,
    TGT_FREE   = 2'd2,
    TGT_ROBIN  = 2'd3
  } tgt_kind_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15,
  parameter int IDX_W   = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PPN_W-1:0]              wr_ppn,
  output logic [ENTRIES-1:0]            valid_q,
  output logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  output logic [ENTRIES-1:0][PPN_W-1:0] ppn_q
);

  // valid bits carry the reset; tag and data storage do not
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (valid_q == '0)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R9
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> (valid_q[$past(wr_idx)] && vpn_q[$past(wr_idx)] == $past(wr_vpn)
                           && ppn_q[$past(wr_idx)] == $past(wr_ppn))); // R4

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match_vec,
  output logic                          any_match,
  output logic [PPN_W-1:0]              ppn_sel
);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (vpn_q[g] == key);
    end
  endgenerate

  assign any_match = |match_vec;

  // AND-OR select: correct because at most one lane matches
  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      ppn_sel = ppn_sel | (ppn_q[i] & {PPN_W{match_vec[i]}});
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R5

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  parameter int IDX_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               fill_en,
  input  logic               use_idx,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] probe_vec,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output tgt_kind_t          kind
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic             named_ok;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (probe_vec[i]) same_idx = IDX_W'(i);
    end
  end

  // descending scan leaves the lowest empty slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid_q;
  assign named_ok = use_idx && (fill_idx <= LAST);

  always_comb begin
    if (|probe_vec) begin
      kind   = TGT_SAME;
      wr_idx = same_idx;
    end else if (named_ok) begin
      kind   = TGT_PICKED;
      wr_idx = fill_idx;
    end else if (any_free) begin
      kind   = TGT_FREE;
      wr_idx = free_idx;
    end else begin
      kind   = TGT_ROBIN;
      wr_idx = rr_ptr;
    end
  end

  assign wr_en = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (wr_en && kind == TGT_ROBIN) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_FREE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == TGT_FREE) |-> !valid_q[wr_idx]); // R6
  AST_ROBIN_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == TGT_ROBIN) |-> (&valid_q)); // R7
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rr_ptr <= LAST); // R7
  AST_NAMED_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == TGT_PICKED) |=> $stable(rr_ptr)); // R8

endmodule

// File: rtl/va_xlat_buffer.sv
module va_xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [VPN_W+OFF_W-1:0]   lookup_va,
  output logic                     hit,
  output logic [PPN_W+OFF_W-1:0]   phys_addr,
  input  logic                     fill_en,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic                     fill_use_idx,
  input  logic [IDX_W-1:0]         fill_idx
);

  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            look_vec;
  logic [ENTRIES-1:0]            probe_vec;
  logic                          probe_any;
  logic [PPN_W-1:0]              look_ppn;
  logic [PPN_W-1:0]              probe_ppn;
  logic                          wr_en;
  logic [IDX_W-1:0]              wr_idx;
  tgt_kind_t                     kind;

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .valid_q(valid_q), .vpn_q(vpn_q), .ppn_q(ppn_q)
  );

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_look (
    .clk(clk), .rst(rst), .valid_q(valid_q), .vpn_q(vpn_q), .ppn_q(ppn_q),
    .key(lookup_va[VA_W-1:OFF_W]),
    .match_vec(look_vec), .any_match(hit), .ppn_sel(look_ppn)
  );

  // second comparator bank probes the fill page for in-place update
  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_probe (
    .clk(clk), .rst(rst), .valid_q(valid_q), .vpn_q(vpn_q), .ppn_q(ppn_q),
    .key(fill_vpn),
    .match_vec(probe_vec), .any_match(probe_any), .ppn_sel(probe_ppn)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
    .use_idx(fill_use_idx), .fill_idx(fill_idx),
    .valid_q(valid_q), .probe_vec(probe_vec),
    .wr_en(wr_en), .wr_idx(wr_idx), .kind(kind)
  );

  assign phys_addr = hit ? {look_ppn, lookup_va[OFF_W-1:0]} : '0;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (phys_addr == '0)); // R3
  AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (rst)
    hit |-> (phys_addr[OFF_W-1:0] == lookup_va[OFF_W-1:0])); // R2
  AST_SAME_KIND: assert property (@(posedge clk) disable iff (rst)
    (fill_en && probe_any) |-> (kind == TGT_SAME)); // R5
  AST_SAME_PPN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !probe_any |-> (probe_ppn == '0)); // R5
  AST_PA_WIDTH: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($countones(look_vec) == 1)); // R2

endmodule

// File: tb/va_xlat_buffer_test.sv
module va_xlat_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst, flush, fill_en, fill_use_idx;
  logic [30:0]   lookup_va;
  logic          hit;
  logic [26:0]   phys_addr;
  logic [18:0]   fill_vpn;
  logic [14:0]   fill_ppn;
  logic [IW-1:0] fill_idx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  va_xlat_buffer #(.ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .flush(flush), .lookup_va(lookup_va),
    .hit(hit), .phys_addr(phys_addr), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_use_idx(fill_use_idx), .fill_idx(fill_idx)
  );

  // {va[30:0], hit, pa[26:0]} after R10 mapping is installed
  localparam logic [58:0] VEC [0:6] = '{
    {31'h0000247C, 1'b1, 27'h7FFF47C},
    {31'h7FFFDABC, 1'b1, 27'h0000ABC},
    {31'h00003000, 1'b0, 27'h0000000},
    {31'h00002FFF, 1'b1, 27'h7FFFFFF},
    {31'h00002000, 1'b1, 27'h7FFF000},
    {31'h7FFFF123, 1'b0, 27'h0000000},
    {31'h00000000, 1'b0, 27'h0000000}
  };

  task automatic look(input logic [30:0] va, input logic eh, input logic [26:0] epa,
                      input string req);
    lookup_va = va;
    #1;
    n_run++;
    if (hit !== eh || phys_addr !== epa) begin
      n_fail++;
      $display("FAIL %s va=%h actual hit=%b pa=%h expected hit=%b pa=%h",
               req, va, hit, phys_addr, eh, epa);
    end
  endtask

  task automatic page(input logic [18:0] vpn, input logic eh, input logic [14:0] eppn,
                      input string req);
    look({vpn, 12'h5A5}, eh, eh ? {eppn, 12'h5A5} : 27'h0, req);
  endtask

  task automatic fill(input logic [18:0] vpn, input logic [14:0] ppn,
                      input logic named, input logic [IW-1:0] idx, input logic fl);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_use_idx = named; fill_idx = idx; flush = fl;
    @(negedge clk);
    fill_en = 1'b0; fill_use_idx = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; fill_en = 1'b0; fill_use_idx = 1'b0;
    fill_idx = '0; fill_vpn = '0; fill_ppn = '0; lookup_va = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    look(31'h0000247C, 1'b0, 27'h0, "R1");
    look(31'h00000000, 1'b0, 27'h0, "R1");

    fill(19'h7FFFD, 15'h0000, 1'b0, '0, 1'b0); // slot 0
    fill(19'h00002, 15'h7FFF, 1'b0, '0, 1'b0); // slot 1
    for (int i = 0; i < 7; i++) begin
      look(VEC[i][58:28], VEC[i][27], VEC[i][26:0], i == 0 ? "R10" : "R2/R3");
    end

    // R4: lookup of the page being filled misses before the edge
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 19'h00010; fill_ppn = 15'h0123;
    look(31'h00010ABC, 1'b0, 27'h0, "R4");
    @(negedge clk);
    fill_en = 1'b0;
    look(31'h00010ABC, 1'b1, 27'h0123ABC, "R4");   // slot 2

    fill(19'h00011, 15'h00AA, 1'b0, '0, 1'b0);     // slot 3, full
    // R5: in-place update
    fill(19'h00002, 15'h1234, 1'b0, '0, 1'b0);
    look(31'h0000247C, 1'b1, 27'h123447C, "R5");
    page(19'h7FFFD, 1'b1, 15'h0000, "R5");
    page(19'h00010, 1'b1, 15'h0123, "R5");
    page(19'h00011, 1'b1, 15'h00AA, "R5");

    // R7: pointer 0 then 1
    fill(19'h00020, 15'h0200, 1'b0, '0, 1'b0);
    page(19'h7FFFD, 1'b0, 15'h0, "R7");
    page(19'h00020, 1'b1, 15'h0200, "R7");
    fill(19'h00021, 15'h0210, 1'b0, '0, 1'b0);
    page(19'h00002, 1'b0, 15'h0, "R7");
    page(19'h00010, 1'b1, 15'h0123, "R7");

    // R8: named slot 3, pointer stays at 2
    fill(19'h00030, 15'h0300, 1'b1, 2'd3, 1'b0);
    page(19'h00011, 1'b0, 15'h0, "R8");
    page(19'h00030, 1'b1, 15'h0300, "R8");
    page(19'h00010, 1'b1, 15'h0123, "R8");

    // R7: pointer 2, 3, wrap to 0
    fill(19'h00022, 15'h0220, 1'b0, '0, 1'b0);
    page(19'h00010, 1'b0, 15'h0, "R7");
    fill(19'h00023, 15'h0230, 1'b0, '0, 1'b0);
    page(19'h00030, 1'b0, 15'h0, "R7");
    fill(19'h00024, 15'h0240, 1'b0, '0, 1'b0);
    page(19'h00020, 1'b0, 15'h0, "R7");
    page(19'h00021, 1'b1, 15'h0210, "R7");

    // R9: flush with a simultaneous fill
    fill(19'h00040, 15'h0400, 1'b0, '0, 1'b1);
    page(19'h00040, 1'b0, 15'h0, "R9");
    page(19'h00021, 1'b0, 15'h0, "R9");
    page(19'h00024, 1'b0, 15'h0, "R9");

    // R6: lowest empty slot first; pointer is at 1
    fill(19'h00050, 15'h0500, 1'b0, '0, 1'b0);     // slot 0
    fill(19'h00051, 15'h0510, 1'b0, '0, 1'b0);     // slot 1
    fill(19'h00052, 15'h0520, 1'b1, 2'd3, 1'b0);   // slot 3
    fill(19'h00053, 15'h0530, 1'b0, '0, 1'b0);     // slot 2
    page(19'h00053, 1'b1, 15'h0530, "R6");
    page(19'h00050, 1'b1, 15'h0500, "R6");
    fill(19'h00054, 15'h0540, 1'b0, '0, 1'b0);     // evicts slot 1
    page(19'h00051, 1'b0, 15'h0, "R6");
    page(19'h00050, 1'b1, 15'h0500, "R6");
    page(19'h00052, 1'b1, 15'h0520, "R6");
    page(19'h00054, 1'b1, 15'h0540, "R6");

    // R1: reset empties a full buffer
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    page(19'h00050, 1'b0, 15'h0, "R1");
    page(19'h00054, 1'b0, 15'h0, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule